// File: doc/BRIEF.md
# Hash Accelerator Register Front-End

This block sits between a 32-bit register bus and a SHA-1/MD5 compression core. The host uses it to load an intermediate digest and a processed-byte count, to describe one chunk of message data through a control word, and to push the chunk into a 64-byte input window. The block then hands the chunk, the algorithm choice and the chunk position to the core, collects the new digest when the core finishes, and tells the host through status bits, an interrupt line and a DMA request line.

A long message is hashed as a series of chunks. The first chunk asks the core to start from the algorithm's initial constants. Every later chunk continues from the digest and byte count that the host has written back. The last chunk carries the close-hash flag. A soft reset clears all state, and a reset-done status bit tells the host when the clearing has finished.

Top module: `hash_reg_frontend`

## Requirements
- R1: The bus register map uses byte offsets. Digest word i sits at 0x00+4i for i=0..4. The byte count is at 0x14, control at 0x18, the data window at 0x1C+4k for k=0..15, revision at 0x5C, mask at 0x60 and system status at 0x64. The digest words and the byte count read back what was written. Revision reads as {major[7:4], minor[3:0]} = 0x13. Window words and unmapped offsets read as zero. After reset, control, count and mask read zero and status reads 1.
- R2: A digest word is kept in the core's numeric form. When the control algorithm bit is 1 (SHA-1), the bus sees that word unchanged. When the bit is 0 (MD5), the bus sees it byte-reversed, both on writes and on reads.
- R3: Control layout: bit0 output-ready, bit1 input-ready, bit2 algorithm (1 = SHA-1), bit3 load initial constants, bit4 close hash, bits 31:5 chunk length in bytes. A control write with bit0 = 0 while the block is idle latches bits 31:2, clears the window to zero and raises input-ready. The same write is ignored while input-ready is high or the core is busy.
- R4: The chunk needs min(16, ceil(length/4)) words. Window writes are accepted only while input-ready is high. On the write that completes the chunk, input-ready drops and core_start pulses for one cycle after that edge. A zero-length chunk starts the core right after the control write.
- R5: While a chunk is handed over, the core ports carry the latched algorithm, load-constants, close-hash and length values, the window words (word k in bits 32k+31:32k, unwritten words zero) and the current digest.
- R6: When the core reports done, the digest takes the core result, the byte count grows by the chunk length, and control bit0 (output-ready) is set.
- R7: irq is high while output-ready is set and mask bit2 (interrupt enable) is set. A control write with bit0 = 1 clears output-ready and therefore irq.
- R8: dma_req is high while mask bit3 (DMA enable) is set and input-ready is high. It drops on the edge that accepts the last word of the chunk.
- R9: Writing mask bit1 starts a soft reset. For one cycle mask bit1 reads 1 and status bit0 reads 0. On the next edge all state is cleared, and status bit0 returns to 1.
- R10: If core completion and an output-ready acknowledge land on the same edge, output-ready ends set. If core completion lands on the soft-reset clearing edge, the clearing wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 7 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Completion interrupt |
| dma_req | output | 1 | Request for more window words |
| core_start | output | 1 | One-cycle chunk start pulse |
| core_sha1 | output | 1 | Algorithm select, 1 = SHA-1 |
| core_load_iv | output | 1 | Start from initial constants |
| core_final | output | 1 | Chunk closes the hash |
| core_len | output | 27 | Chunk length in bytes |
| core_block | output | 512 | Window contents |
| core_dig | output | 160 | Current digest, numeric form |
| core_done | input | 1 | Core finished the chunk |
| core_result | input | 160 | Core's new digest |

## Verification
Two pairs of events can share an edge. The first is core completion and the host's output-ready acknowledge. The bench drives both on one edge and expects output-ready to stay set while the new digest is loaded. The second is core completion and the soft-reset clearing edge. The bench asserts done in the cycle after the soft-reset write and expects output-ready, the count and the digest to all read zero afterward. A sweep over both algorithms and lengths 0, 1, 4, 5, 17, 63, 64 and 100 bytes chains chunks and compares the digests against an arithmetic model of the stand-in core.

// File: rtl/hash_reg_frontend.sv
module hash_reg_frontend #(
  parameter int DIG_WORDS = 5,
  parameter int BLK_WORDS = 16,
  parameter logic [3:0] REV_MAJOR = 4'd1,
  parameter logic [3:0] REV_MINOR = 4'd3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_en,
  input  logic                     bus_we,
  input  logic [6:0]               bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  output logic                     irq,
  output logic                     dma_req,
  output logic                     core_start,
  output logic                     core_sha1,
  output logic                     core_load_iv,
  output logic                     core_final,
  output logic [26:0]              core_len,
  output logic [BLK_WORDS*32-1:0]  core_block,
  output logic [DIG_WORDS*32-1:0]  core_dig,
  input  logic                     core_done,
  input  logic [DIG_WORDS*32-1:0]  core_result
);

  localparam int IDX_W = $clog2(BLK_WORDS + 1);
  localparam int BLK_BYTES = BLK_WORDS * 4;
  localparam logic [4:0] A_CNT  = 5'd5;
  localparam logic [4:0] A_CTRL = 5'd6;
  localparam logic [4:0] A_DATA = 5'd7;
  localparam logic [4:0] A_REV  = 5'd23;
  localparam logic [4:0] A_MASK = 5'd24;
  localparam logic [4:0] A_STAT = 5'd25;

  logic [31:0]      dig [DIG_WORDS];
  logic [31:0]      win [BLK_WORDS];
  logic [31:0]      cnt;
  logic [26:0]      len_q;
  logic             sha1_q, ld_q, fin_q;
  logic             in_rdy, out_rdy, busy, start_q;
  logic [IDX_W-1:0] wcnt;
  logic             irq_en, dma_en, idle_en, srst, rst_done;

  logic [4:0]       widx;
  logic             wr;
  logic [IDX_W-1:0] need_new, need_q;

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [IDX_W-1:0] words_of(input logic [26:0] l);
    return (l >= 27'(BLK_BYTES)) ? IDX_W'(BLK_WORDS) : IDX_W'((l + 27'd3) >> 2);
  endfunction

  assign widx     = bus_addr[6:2];
  assign wr       = bus_en && bus_we && (bus_addr[1:0] == 2'b00);
  assign need_new = words_of(bus_wdata[31:5]);
  assign need_q   = words_of(len_q);

  assign irq          = irq_en && out_rdy;
  assign dma_req      = dma_en && in_rdy;
  assign core_start   = start_q;
  assign core_sha1    = sha1_q;
  assign core_load_iv = ld_q;
  assign core_final   = fin_q;
  assign core_len     = len_q;

  always_comb begin
    for (int i = 0; i < DIG_WORDS; i++) core_dig[i*32 +: 32] = dig[i];
    for (int k = 0; k < BLK_WORDS; k++) core_block[k*32 +: 32] = win[k];
  end

  always_comb begin
    bus_rdata = '0;
    if (widx < 5'(DIG_WORDS)) begin
      for (int i = 0; i < DIG_WORDS; i++)
        if (widx == 5'(i)) bus_rdata = sha1_q ? dig[i] : bswap(dig[i]);
    end else begin
      case (widx)
        A_CNT:   bus_rdata = cnt;
        A_CTRL:  bus_rdata = {len_q, fin_q, ld_q, sha1_q, in_rdy, out_rdy};
        A_REV:   bus_rdata = {24'd0, REV_MAJOR, REV_MINOR};
        A_MASK:  bus_rdata = {28'd0, dma_en, irq_en, srst, idle_en};
        A_STAT:  bus_rdata = {31'd0, rst_done};
        default: bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      for (int i = 0; i < DIG_WORDS; i++) dig[i] <= '0;
      for (int k = 0; k < BLK_WORDS; k++) win[k] <= '0;
      cnt <= '0;  len_q <= '0;  sha1_q <= 1'b0;  ld_q <= 1'b0;  fin_q <= 1'b0;
      in_rdy <= 1'b0;  out_rdy <= 1'b0;  busy <= 1'b0;  start_q <= 1'b0;
      wcnt <= '0;  irq_en <= 1'b0;  dma_en <= 1'b0;  idle_en <= 1'b0;
      srst <= 1'b0;  rst_done <= 1'b1;
    end else begin
      start_q <= 1'b0;
      if (wr) begin
        for (int i = 0; i < DIG_WORDS; i++)
          if (widx == 5'(i)) dig[i] <= sha1_q ? bus_wdata : bswap(bus_wdata);
        for (int k = 0; k < BLK_WORDS; k++)
          if (in_rdy && widx == A_DATA + 5'(k)) begin
            win[k] <= bus_wdata;
            wcnt   <= wcnt + 1'b1;
            if (wcnt + 1'b1 == need_q) begin
              in_rdy  <= 1'b0;
              start_q <= 1'b1;
              busy    <= 1'b1;
            end
          end
        case (widx)
          A_CNT: cnt <= bus_wdata;
          A_CTRL:
            if (bus_wdata[0]) out_rdy <= 1'b0;
            else if (!busy && !in_rdy) begin
              len_q  <= bus_wdata[31:5];
              fin_q  <= bus_wdata[4];
              ld_q   <= bus_wdata[3];
              sha1_q <= bus_wdata[2];
              wcnt   <= '0;
              for (int k = 0; k < BLK_WORDS; k++) win[k] <= '0;
              if (need_new == '0) begin
                start_q <= 1'b1;
                busy    <= 1'b1;
              end else begin
                in_rdy <= 1'b1;
              end
            end
          A_MASK: begin
            idle_en <= bus_wdata[0];
            irq_en  <= bus_wdata[2];
            dma_en  <= bus_wdata[3];
            if (bus_wdata[1]) begin
              srst     <= 1'b1;
              rst_done <= 1'b0;
            end
          end
          default: ;
        endcase
      end
      if (core_done && busy) begin
        for (int i = 0; i < DIG_WORDS; i++) dig[i] <= core_result[i*32 +: 32];
        cnt     <= cnt + 32'(len_q);
        out_rdy <= 1'b1;
        busy    <= 1'b0;
      end
    end
  end

  p_done_sets_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (core_done && busy && !srst) |=> out_rdy);

  p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);

  p_window_idle_engine_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_rdy |-> !busy);

  p_dma_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> !dma_req);

  p_soft_reset_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (rst_done && cnt == '0 && !busy && !out_rdy));

  p_ready_wins_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (core_done && busy && !srst && wr && widx == A_CTRL && bus_wdata[0]) |=> out_rdy);

endmodule

// File: tb/test_hash_reg_frontend.sv
module test_hash_reg_frontend;
  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_we = 0;
  logic [6:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, dma_req, core_start, core_sha1, core_load_iv, core_final, core_done = 0;
  logic [26:0] core_len;
  logic [511:0] blk;
  logic [159:0] cdig, cres = '0;

  hash_reg_frontend i_hash_reg_frontend (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .dma_req(dma_req),
    .core_start(core_start), .core_sha1(core_sha1), .core_load_iv(core_load_iv),
    .core_final(core_final), .core_len(core_len), .core_block(blk), .core_dig(cdig),
    .core_done(core_done), .core_result(cres));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] bd [16];
  logic [31:0] exp_dig [5];
  logic [31:0] exp_cnt = 0;
  logic cur_irq_en = 0;

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [31:0] iv(input int i);
    return 32'h6745_2301 + 32'(i) * 32'h1111_1111;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata; bus_en = 0;
  endtask

  task automatic finish_core(input bit with_ack);
    logic [31:0] xb;
    @(negedge clk);
    xb = 0;
    for (int k = 0; k < 16; k++) xb ^= blk[k*32 +: 32];
    for (int i = 0; i < 5; i++)
      cres[i*32 +: 32] = (core_load_iv ? iv(i) : cdig[i*32 +: 32]) + xb + 32'(i) +
                         (core_final ? 32'h100 : 32'h0);
    core_done = 1;
    if (with_ack) begin bus_en = 1; bus_we = 1; bus_addr = 7'h18; bus_wdata = 32'h1; end
    @(negedge clk); core_done = 0; bus_en = 0; bus_we = 0;
  endtask

  task automatic do_chunk(input bit sha, input bit ld, input bit fin, input int len,
                          input int seed, input bit dma, input bit irqe, input int mode);
    logic [31:0] v, xb;
    int need;
    wr(7'h60, {28'd0, dma, irqe, 2'b00});
    cur_irq_en = irqe;
    need = (len >= 64) ? 16 : (len + 3) / 4;
    for (int k = 0; k < 16; k++) bd[k] = 0;
    wr(7'h18, {27'(len), fin, ld, sha, 2'b00});
    if (need == 0) begin
      chk("R4 zero-length start", 32'(core_start), 1);
      rd(7'h18, v); chk("R3 no input-ready for empty chunk", 32'(v[1]), 0);
    end else begin
      rd(7'h18, v); chk("R3 input-ready raised", 32'(v[1]), 1);
      chk("R8 dma_req while awaiting words", 32'(dma_req), 32'(dma));
      wr(7'h18, {27'(len + 9), 1'b0, 1'b0, ~sha, 2'b00});
      rd(7'h18, v); chk("R3 control ignored while loading", v & 32'hFFFF_FFFC,
                        {27'(len), fin, ld, sha, 2'b00});
      for (int k = 0; k < need; k++) begin
        bd[k] = 32'(seed) * 32'h0100_0193 ^ 32'(k) * 32'h9E37_79B9;
        wr(7'(8'h1C + 8'(k * 4)), bd[k]);
      end
      chk("R4 start after last word", 32'(core_start), 1);
      chk("R8 dma_req dropped", 32'(dma_req), 0);
      rd(7'h18, v); chk("R4 input-ready dropped", 32'(v[1]), 0);
    end
    for (int k = 0; k < 16; k++) chk("R5 window word to core", blk[k*32 +: 32], bd[k]);
    chk("R5 core length", 32'(core_len), 32'(len));
    chk("R5 core flags", {29'd0, core_sha1, core_load_iv, core_final}, {29'd0, sha, ld, fin});
    xb = 0;
    for (int k = 0; k < 16; k++) xb ^= bd[k];
    for (int i = 0; i < 5; i++)
      exp_dig[i] = (ld ? iv(i) : exp_dig[i]) + xb + 32'(i) + (fin ? 32'h100 : 32'h0);
    exp_cnt += 32'(len);
    finish_core(mode == 2);
    rd(7'h18, v); chk("R6/R10 output-ready set", 32'(v[0]), 1);
    rd(7'h14, v); chk("R6 byte count advanced", v, exp_cnt);
    for (int i = 0; i < 5; i++) begin
      rd(7'(i * 4), v);
      chk("R2 R6 digest readback", v, sha ? exp_dig[i] : bswap(exp_dig[i]));
    end
    chk("R7 irq follows enable", 32'(irq), 32'(irqe));
    if (mode != 1) begin
      wr(7'h18, 32'h1);
      rd(7'h18, v); chk("R7 ack clears output-ready", 32'(v[0]), 0);
      chk("R7 irq cleared", 32'(irq), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, saved;
    int lens [8] = '{0, 1, 4, 5, 17, 63, 64, 100};
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(7'h18, v); chk("R1 control reset", v, 0);
    rd(7'h14, v); chk("R1 count reset", v, 0);
    rd(7'h60, v); chk("R1 mask reset", v, 0);
    rd(7'h64, v); chk("R1 status reset", v, 1);
    rd(7'h5C, v); chk("R1 revision", v, 32'h13);
    rd(7'h68, v); chk("R1 unmapped reads zero", v, 0);
    chk("R7 irq reset", 32'(irq), 0);
    chk("R8 dma reset", 32'(dma_req), 0);
    for (int i = 0; i < 5; i++) begin
      wr(7'(i * 4), 32'hA0B1_C2D3 + 32'(i));
      rd(7'(i * 4), v); chk("R1 digest readback", v, 32'hA0B1_C2D3 + 32'(i));
      chk("R2 MD5 byte order to core", cdig[i*32 +: 32], bswap(32'hA0B1_C2D3 + 32'(i)));
    end
    wr(7'h14, 32'h0000_0BEE);
    rd(7'h14, v); chk("R1 count readback", v, 32'h0000_0BEE);
    for (int s = 0; s < 2; s++) begin
      wr(7'h14, 0); exp_cnt = 0;
      for (int j = 0; j < 8; j++) begin
        if (j == 5) begin wr(7'h14, 32'h1000); exp_cnt = 32'h1000; end
        do_chunk(s[0], j == 0, j == 7, lens[j], s * 16 + j + 1, j[0], j[1],
                 (j == 3) ? 1 : (j == 4) ? 2 : 0);
      end
    end
    wr(7'h00, 32'h1234_5678);
    chk("R2 SHA-1 order to core", cdig[31:0], 32'h1234_5678);
    rd(7'h1C, v); chk("R1 window reads zero", v, 0);
    saved = blk[95:64];
    wr(7'h24, 32'hDEAD_BEEF);
    chk("R4 window write ignored when idle", blk[95:64], saved);
    wr(7'h18, {27'd4, 1'b0, 1'b1, 1'b1, 2'b00});
    wr(7'h1C, 32'h5555_0000);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = 7'h60; bus_wdata = 32'h2;
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = 7'h64; core_done = 1; cres = '1;
    #1 chk("R9 reset-done low while pending", 32'(bus_rdata[0]), 0);
    bus_addr = 7'h60;
    #1 chk("R9 soft-reset bit reads set", 32'(bus_rdata[1]), 1);
    bus_en = 0;
    @(negedge clk); core_done = 0;
    rd(7'h18, v); chk("R10 clearing beats completion", v, 0);
    rd(7'h14, v); chk("R9 count cleared", v, 0);
    rd(7'h00, v); chk("R9 digest cleared", v, 0);
    rd(7'h64, v); chk("R9 reset-done back high", v, 1);
    rd(7'h60, v); chk("R9 mask cleared", v, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule